// File: doc/BRIEF.md
# Idle-Depth Governor

This block chooses how deep a core should sleep the next time it goes idle. It picks one of three depths: shallow (C1), intermediate (C2) and deep (C3). Another block measures each idle period. When the period ends, that block sends a one-cycle end pulse together with the period's length in clock ticks. The governor compares the length against programmable exit-latency thresholds for the two deeper depths. It promotes the selection after a run of long idle periods and demotes it at once after a single short one.

The governor also judges its own choices. A deep choice is wrong when the idle period that followed was shorter than a programmable break-even length for that depth. A shallow choice is wrong when the period was long enough to have justified C2. A wrong-decision counter and a total-decision counter are exposed so that an error ratio can be formed. Both counters saturate.

Top module: `cstate_governor`

## Requirements
- R1: After a synchronous active-high reset, `sel_state` is 1 (C1), `sel_valid` is 0, and both counters are 0. Depth codes are: 1 = C1, 2 = C2, 3 = C3.
- R2: `sel_valid` is high for exactly the cycle after each cycle in which `idle_done` is sampled high, and is low otherwise. `sel_state` changes only in that cycle.
- R3: While the selection is C1, four consecutive idle periods each strictly longer than `lat_c2` move the selection to C2 on the fourth.
- R4: While the selection is C2, ten consecutive idle periods each strictly longer than `lat_c3` move the selection to C3 on the tenth.
- R5: An idle period that does not meet the current depth's promotion condition clears the consecutive-period count to zero. This includes a length exactly equal to the latency.
- R6: In C2, a period strictly shorter than `lat_c2` demotes the selection to C1. In C3, a period strictly shorter than `lat_c3` demotes it to C2. A demotion clears the consecutive-period count.
- R7: C1 is never demoted, whatever the length of the period.
- R8: `wrong_cnt` increments on a period judged against the depth in force when that period began. In C1 the period is wrong when its length is strictly greater than `lat_c2`. In C2 it is wrong when its length is strictly less than `brk_c2`. In C3 it is wrong when its length is strictly less than `brk_c3`.
- R9: `total_cnt` increments once for every idle period reported.
- R10: Both counters saturate at all ones and hold there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_done | input | 1 | One-cycle pulse marking the end of an idle period |
| idle_len | input | LEN_W | Length of the idle period that just ended, in ticks |
| lat_c2 | input | LEN_W | Exit latency of C2 |
| lat_c3 | input | LEN_W | Exit latency of C3 |
| brk_c2 | input | LEN_W | Break-even idle length for C2 |
| brk_c3 | input | LEN_W | Break-even idle length for C3 |
| sel_state | output | 2 | Registered depth selection for the next idle period |
| sel_valid | output | 1 | Strobe marking an updated selection |
| wrong_cnt | output | CNT_W | Saturating count of wrong decisions |
| total_cnt | output | CNT_W | Saturating count of all decisions |

## Verification
A miscounted streak register does not show up at once. It appears at the ports only when a promotion arrives one period early or late, so the bench drives streaks of exactly length minus one, broken by a single non-qualifying period. A wrong depth register is visible on the very next strobe, both in `sel_state` and in the following period's wrong-decision judgement. A counter fault shows in the cycle after the pulse. Saturation is reached with a narrow counter width so that the hold-at-all-ones behaviour is seen directly.

// File: rtl/gov_pkg.sv
package gov_pkg;
  typedef enum logic [1:0] {
    DEPTH_C1 = 2'd1,
    DEPTH_C2 = 2'd2,
    DEPTH_C3 = 2'd3
  } depth_e;
endpackage

// File: rtl/gov_policy.sv
module gov_policy
  import gov_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int PROMO_C2 = 4,
  parameter int PROMO_C3 = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_done,
  input  logic [LEN_W-1:0] idle_len,
  input  logic [LEN_W-1:0] lat_c2,
  input  logic [LEN_W-1:0] lat_c3,
  output depth_e           depth
);
  localparam int MAX_RUN = (PROMO_C3 > PROMO_C2) ? PROMO_C3 : PROMO_C2;
  localparam int STRK_W  = $clog2(MAX_RUN + 1);

  depth_e            depth_q, depth_d;
  logic [STRK_W-1:0] run_q, run_d;

  always_comb begin
    depth_d = depth_q;
    run_d   = run_q;
    unique case (depth_q)
      DEPTH_C2: begin
        if (idle_len < lat_c2) begin
          depth_d = DEPTH_C1;
          run_d   = '0;
        end else if (idle_len > lat_c3) begin
          if (run_q == STRK_W'(PROMO_C3 - 1)) begin
            depth_d = DEPTH_C3;
            run_d   = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d = '0;
        end
      end
      DEPTH_C3: begin
        run_d = '0;
        if (idle_len < lat_c3) depth_d = DEPTH_C2;
      end
      default: begin
        if (idle_len > lat_c2) begin
          if (run_q == STRK_W'(PROMO_C2 - 1)) begin
            depth_d = DEPTH_C2;
            run_d   = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= DEPTH_C1;
      run_q   <= '0;
    end else if (idle_done) begin
      depth_q <= depth_d;
      run_q   <= run_d;
    end
  end

  assign depth = depth_q;

  // R4 / R3: the run count never reaches the promotion length
  p_run_bound_r4: assert property (@(posedge clk) disable iff (rst)
    run_q < STRK_W'(MAX_RUN));
  // R6: the deepest level keeps no run
  p_deep_no_run_r6: assert property (@(posedge clk) disable iff (rst)
    depth_q == DEPTH_C3 |-> run_q == '0);
  // R7: C1 stays put after a short period
  p_floor_r7: assert property (@(posedge clk) disable iff (rst)
    idle_done && depth_q == DEPTH_C1 && idle_len <= lat_c2 |=> depth_q == DEPTH_C1);
endmodule

// File: rtl/gov_judge.sv
module gov_judge
  import gov_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  depth_e           depth,
  input  logic [LEN_W-1:0] idle_len,
  input  logic [LEN_W-1:0] lat_c2,
  input  logic [LEN_W-1:0] brk_c2,
  input  logic [LEN_W-1:0] brk_c3,
  output logic             wrong
);
  always_comb begin
    unique case (depth)
      DEPTH_C2: wrong = idle_len < brk_c2;
      DEPTH_C3: wrong = idle_len < brk_c3;
      default:  wrong = idle_len > lat_c2;
    endcase
  end
endmodule

// File: rtl/gov_sat_cnt.sv
module gov_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)             q_r <= '0;
    else if (inc && !(&q_r)) q_r <= q_r + 1'b1;
  end

  assign q = q_r;

  // R10: once full, the count holds
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    &q_r |=> &q_r);
  // R9: a non-full counter steps by one per request
  p_step_r9: assert property (@(posedge clk) disable iff (rst)
    inc && !(&q_r) |=> q_r == $past(q_r) + 1'b1);
  // R9: no request, no change
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(q_r));
endmodule

// File: rtl/cstate_governor.sv
module cstate_governor
  import gov_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 32,
  parameter int PROMO_C2 = 4,
  parameter int PROMO_C3 = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_done,
  input  logic [LEN_W-1:0] idle_len,
  input  logic [LEN_W-1:0] lat_c2,
  input  logic [LEN_W-1:0] lat_c3,
  input  logic [LEN_W-1:0] brk_c2,
  input  logic [LEN_W-1:0] brk_c3,
  output logic [1:0]       sel_state,
  output logic             sel_valid,
  output logic [CNT_W-1:0] wrong_cnt,
  output logic [CNT_W-1:0] total_cnt
);
  depth_e depth;
  logic   wrong;
  logic   valid_q;

  gov_policy #(.LEN_W(LEN_W), .PROMO_C2(PROMO_C2), .PROMO_C3(PROMO_C3)) u_policy (
    .clk(clk), .rst(rst), .idle_done(idle_done), .idle_len(idle_len),
    .lat_c2(lat_c2), .lat_c3(lat_c3), .depth(depth)
  );

  gov_judge #(.LEN_W(LEN_W)) u_judge (
    .depth(depth), .idle_len(idle_len), .lat_c2(lat_c2),
    .brk_c2(brk_c2), .brk_c3(brk_c3), .wrong(wrong)
  );

  gov_sat_cnt #(.W(CNT_W)) u_wrong_cnt (
    .clk(clk), .rst(rst), .inc(idle_done && wrong), .q(wrong_cnt)
  );

  gov_sat_cnt #(.W(CNT_W)) u_total_cnt (
    .clk(clk), .rst(rst), .inc(idle_done), .q(total_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= idle_done;
  end

  assign sel_valid = valid_q;
  assign sel_state = depth;

  // R2: every pulse yields a strobe
  p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    idle_done |=> sel_valid);
  // R2: without a pulse, no strobe and no change of selection
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !idle_done |=> !sel_valid && $stable(sel_state));
  // R6: selection moves at most one level per decision
  p_one_level_r6: assert property (@(posedge clk) disable iff (rst)
    idle_done |=> (sel_state == $past(sel_state)) ||
                  (sel_state == $past(sel_state) + 2'd1) ||
                  (sel_state + 2'd1 == $past(sel_state)));
  // R8: wrong decisions never outnumber decisions
  p_wrong_le_total_r8: assert property (@(posedge clk) disable iff (rst)
    wrong_cnt <= total_cnt);
  // R1: encoding stays in the legal range
  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    sel_state != 2'd0);
endmodule

// File: tb/tb_cstate_governor.sv
module tb_cstate_governor;
  localparam int LEN_W = 16;
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] FULL = '1;

  logic             clk = 1'b0;
  logic             rst;
  logic             idle_done;
  logic [LEN_W-1:0] idle_len, lat_c2, lat_c3, brk_c2, brk_c3;
  logic [1:0]       sel_state;
  logic             sel_valid;
  logic [CNT_W-1:0] wrong_cnt, total_cnt;

  int checks = 0;
  int fails  = 0;

  int m_sel, m_run, m_wrong, m_total;

  cstate_governor #(.LEN_W(LEN_W), .CNT_W(CNT_W), .PROMO_C2(4), .PROMO_C3(10)) dut (
    .clk(clk), .rst(rst), .idle_done(idle_done), .idle_len(idle_len),
    .lat_c2(lat_c2), .lat_c3(lat_c3), .brk_c2(brk_c2), .brk_c3(brk_c3),
    .sel_state(sel_state), .sel_valid(sel_valid),
    .wrong_cnt(wrong_cnt), .total_cnt(total_cnt)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model following the requirements
  task automatic model_step(input int len);
    int l2, l3, b2, b3;
    bit w;
    l2 = lat_c2; l3 = lat_c3; b2 = brk_c2; b3 = brk_c3;
    if (m_sel == 1)      w = len > l2;
    else if (m_sel == 2) w = len < b2;
    else                 w = len < b3;
    if (w && m_wrong < 255) m_wrong++;
    if (m_total < 255) m_total++;
    if (m_sel == 1) begin
      if (len > l2) begin
        if (m_run == 3) begin m_sel = 2; m_run = 0; end else m_run++;
      end else m_run = 0;
    end else if (m_sel == 2) begin
      if (len < l2) begin m_sel = 1; m_run = 0; end
      else if (len > l3) begin
        if (m_run == 9) begin m_sel = 3; m_run = 0; end else m_run++;
      end else m_run = 0;
    end else begin
      m_run = 0;
      if (len < l3) m_sel = 2;
    end
  endtask

  task automatic idle(input int len, input string req);
    @(negedge clk);
    idle_done = 1'b1;
    idle_len  = LEN_W'(len);
    model_step(len);
    @(negedge clk);
    idle_done = 1'b0;
    chk(sel_valid == 1'b1, "R2 strobe", sel_valid, 1);
    chk(sel_state == 2'(m_sel), req, sel_state, m_sel);
    chk(wrong_cnt == CNT_W'(m_wrong), "R8 wrong_cnt", wrong_cnt, m_wrong);
    chk(total_cnt == CNT_W'(m_total), "R9 total_cnt", total_cnt, m_total);
    @(negedge clk);
    chk(sel_valid == 1'b0, "R2 strobe low", sel_valid, 0);
    chk(sel_state == 2'(m_sel), "R2 selection held", sel_state, m_sel);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; idle_done = 1'b0; idle_len = '0;
    lat_c2 = 16'd100; lat_c3 = 16'd400; brk_c2 = 16'd150; brk_c3 = 16'd600;
    m_sel = 1; m_run = 0; m_wrong = 0; m_total = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sel_state == 2'd1, "R1 reset depth", sel_state, 1);
    chk(sel_valid == 1'b0, "R1 reset strobe", sel_valid, 0);
    chk(wrong_cnt == 0 && total_cnt == 0, "R1 reset counters", total_cnt, 0);

    // R5: three long, one exactly at latency, then four long -> C2 (R3)
    repeat (3) idle(200, "R3 run building");
    idle(100, "R5 equal length breaks run");
    repeat (3) idle(200, "R5 still C1 after restart");
    chk(sel_state == 2'd1, "R5 C1 before fourth", sel_state, 1);
    idle(200, "R3 promote to C2");
    chk(sel_state == 2'd2, "R3 now C2", sel_state, 2);

    // R4 with a break after nine
    repeat (9) idle(500, "R4 run building");
    idle(300, "R5 mid period breaks run");
    repeat (9) idle(500, "R4 restart");
    chk(sel_state == 2'd2, "R4 C2 before tenth", sel_state, 2);
    idle(500, "R4 promote to C3");
    chk(sel_state == 2'd3, "R4 now C3", sel_state, 3);

    // R6 demotions, R8 wrong in deep states
    idle(450, "R6 C3 kept, wrong by break-even");
    idle(399, "R6 demote C3 to C2");
    chk(sel_state == 2'd2, "R6 C3->C2", sel_state, 2);
    idle(99, "R6 demote C2 to C1");
    chk(sel_state == 2'd1, "R6 C2->C1", sel_state, 1);
    idle(0, "R7 C1 floor zero length");
    chk(sel_state == 2'd1, "R7 C1 floor", sel_state, 1);
    idle(101, "R8 long period in C1 wrong");

    // Constrained random mix
    for (int i = 0; i < 320; i++) begin
      int kind, len;
      kind = $urandom_range(0, 9);
      if (kind < 2)      len = $urandom_range(0, 99);
      else if (kind < 4) len = $urandom_range(100, 400);
      else               len = $urandom_range(401, 2000);
      if (i == 160) begin
        lat_c2 = 16'd50; lat_c3 = 16'd250; brk_c2 = 16'd80; brk_c3 = 16'd300;
      end
      idle(len, "R6 random sequence depth");
    end

    chk(total_cnt == FULL, "R10 total saturated", total_cnt, 255);
    idle(10, "R10 after saturation");
    chk(total_cnt == FULL, "R10 total holds", total_cnt, 255);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule